// File: doc/BRIEF.md
# Stack and Interrupt Sequencer

This block owns the stack pointer of a small pipelined processor and sequences every change of control flow that goes through the stack. These are push, pop, subroutine call and return, the single non-maskable hardware interrupt, the return from that interrupt, and the start-up after reset. Each operation drives one 32-bit memory access per cycle. The memory is word addressable, with 16-bit words over a 2^AW-word space, and one access covers two neighbouring words. The block also tells the fetch stage when, and with what value, to reload the program counter.

The stack grows downward. Each 32-bit entry takes two words. A push writes at the current pointer and then moves the pointer down. A pop first moves the pointer up and then reads.

An interrupt edge is remembered until the pipeline reports that it has drained. The block then stores the address of the next instruction on the stack, copies the condition flags into a shadow register, and loads the program counter from the 32-bit value at word address 1. The matching interrupt return pops the program counter and hands the saved flags back. While a multi-cycle sequence runs, a busy output holds off fetch, and any operation code offered during that time has no effect.

Top module: `stack_seq`

## Requirements
- R1: While reset is high, the stack pointer reads 2^AW-2 and busy is high. In the first cycle after the first clock edge with reset low, pc_load pulses with the 32-bit value read at word address 0. Busy is low from the cycle after that pulse.
- R2: A 32-bit memory value at address A has bits 15:0 in word A and bits 31:16 in word A+1 (mod 2^AW). Write enable and read enable are never high together.
- R3: Operation code 1 (push) writes reg_data at the address equal to the stack pointer in the same cycle. The stack pointer is 2 lower after the clock edge.
- R4: Operation code 2 (pop) reads at stack pointer + 2 in the same cycle, and the stack pointer is 2 higher after the edge. In the next cycle busy is high and pop_valid presents the value read.
- R5: Operation code 3 (call) writes pc_in+1 at the stack pointer and lowers the pointer by 2. In the same cycle it pulses pc_load with reg_data.
- R6: Operation code 4 (return) performs the pop access of R4. In the next cycle it pulses pc_load with the value read, and flags_load stays low.
- R7: Stack pointer arithmetic wraps modulo 2^AW. A pop at 2^AW-2 reads at address 0 and leaves the pointer at 0. A push at 0 leaves the pointer at 2^AW-2.
- R8: A rising edge on irq is latched and held. It is taken only in an idle cycle with pipe_empty high and operation code 0 (none). A stack operation offered in the same cycle as the edge is served first.
- R9: When the interrupt is taken, the block writes pc_in at the stack pointer, lowers the pointer by 2, and raises busy in that same cycle. In the next cycle it reads at address 1. In the cycle after that it pulses pc_load with the value read. flags_load stays low throughout.
- R10: Operation code 5 (interrupt return) performs the pop access of R4. In the next cycle it pulses pc_load with the value read, and pulses flags_load with the flags that flags_in carried in the cycle the interrupt was taken.
- R11: Between interrupt entry and the completion of the interrupt return, irq edges are discarded and no interrupt entry occurs.
- R12: An operation code offered while busy is high causes no memory write and no change of the stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_code | input | 3 | Stack operation: 0 none, 1 push, 2 pop, 3 call, 4 return, 5 interrupt return |
| pc_in | input | DW | Address of the next instruction from fetch |
| reg_data | input | DW | Register operand: push data or call target |
| flags_in | input | FW | Current condition flags |
| irq | input | 1 | Non-maskable interrupt request |
| pipe_empty | input | 1 | High when no instruction is in flight |
| mem_rdata | input | DW | Read data, valid the cycle after a read |
| mem_addr | output | AW | Word address of the access |
| mem_wdata | output | DW | Write data |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read enable |
| pc_load | output | 1 | Program counter reload strobe |
| pc_value | output | DW | Program counter reload value |
| pop_valid | output | 1 | Popped register value is present |
| pop_data | output | DW | Popped register value |
| flags_load | output | 1 | Flag restore strobe |
| flags_value | output | FW | Flags to restore |
| busy | output | 1 | Multi-cycle sequence in progress; fetch must stall |
| sp_out | output | AW | Current stack pointer |

## Verification
The interrupt edge and a stack operation can land in the same cycle. The bench raises irq in the very cycle a push is presented, while pipe_empty is still low. It then checks three things: the push writes at the old pointer, no entry occurs while the pipeline is busy, and the later entry stores pc_in one slot below the pushed word. An interrupt edge can also arrive while the block is already in service. The bench provokes this by toggling irq before the interrupt return, and judges it by the absence of any write during idle cycles with pipe_empty high.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_RTI  = 3'd5
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_BOOT_W,
    ST_IDLE,
    ST_POP_W,
    ST_VEC,
    ST_VEC_W
  } stk_state_e;

  // one 32-bit entry spans two words
  function automatic logic [31:0] slot_below(input logic [31:0] s);
    return s - 32'd2;
  endfunction

  function automatic logic [31:0] slot_above(input logic [31:0] s);
    return s + 32'd2;
  endfunction

  function automatic logic [31:0] return_addr(input logic [31:0] pc);
    return pc + 32'd1;
  endfunction

endpackage

// File: rtl/stk_sp_unit.sv
module stk_sp_unit #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sp_dec,
  input  logic          sp_inc,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] sp_up
);
  import stk_pkg::*;

  localparam logic [AW-1:0] SP_INIT = AW'((64'd1 << AW) - 64'd2);

  logic [AW-1:0] sp_q;
  logic [AW-1:0] sp_dn;

  assign sp_up = AW'(slot_above(32'(sp_q)));
  assign sp_dn = AW'(slot_below(32'(sp_q)));
  assign sp    = sp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= SP_INIT;
    end else if (sp_dec) begin
      sp_q <= sp_dn;
    end else if (sp_inc) begin
      sp_q <= sp_up;
    end
  end

endmodule

// File: rtl/stk_irq_unit.sv
module stk_irq_unit #(
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq,
  input  logic          take,
  input  logic          done,
  input  logic [FW-1:0] flags_in,
  output logic          pending,
  output logic          in_isr,
  output logic [FW-1:0] shadow
);

  logic irq_q;
  logic irq_edge;

  assign irq_edge = irq & ~irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= 1'b0;
      pending <= 1'b0;
      in_isr  <= 1'b0;
      shadow  <= '0;
    end else begin
      irq_q <= irq;
      if (take) begin
        pending <= 1'b0;
        in_isr  <= 1'b1;
        shadow  <= flags_in;
      end else begin
        if (irq_edge && !in_isr) begin
          pending <= 1'b1;
        end
        if (done) begin
          in_isr <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl #(
  parameter int AW = 20,
  parameter int DW = 32,
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    op_code,
  input  logic [DW-1:0] pc_in,
  input  logic [DW-1:0] reg_data,
  input  logic [DW-1:0] mem_rdata,
  input  logic [AW-1:0] sp,
  input  logic [AW-1:0] sp_up,
  input  logic          pending,
  input  logic          pipe_empty,
  input  logic [FW-1:0] shadow,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic          pc_load,
  output logic [DW-1:0] pc_value,
  output logic          pop_valid,
  output logic [DW-1:0] pop_data,
  output logic          flags_load,
  output logic [FW-1:0] flags_value,
  output logic          busy,
  output logic          sp_dec,
  output logic          sp_inc,
  output logic          ev_push,
  output logic          ev_pop_issue,
  output logic          ev_int_take,
  output logic          ev_rti_done
);
  import stk_pkg::*;

  localparam logic [AW-1:0] BOOT_ADDR = AW'(0);
  localparam logic [AW-1:0] VEC_ADDR  = AW'(1);

  stk_state_e state_q, state_d;
  stk_op_e    kind_q, kind_d;
  stk_op_e    op;

  assign op = stk_op_e'(op_code);

  always_comb begin
    state_d      = state_q;
    kind_d       = kind_q;
    mem_addr     = sp;
    mem_wdata    = '0;
    mem_we       = 1'b0;
    mem_re       = 1'b0;
    pc_load      = 1'b0;
    pc_value     = '0;
    pop_valid    = 1'b0;
    pop_data     = '0;
    flags_load   = 1'b0;
    flags_value  = '0;
    busy         = 1'b0;
    sp_dec       = 1'b0;
    sp_inc       = 1'b0;
    ev_push      = 1'b0;
    ev_pop_issue = 1'b0;
    ev_int_take  = 1'b0;
    ev_rti_done  = 1'b0;
    unique case (state_q)
      ST_BOOT: begin
        busy     = 1'b1;
        mem_re   = 1'b1;
        mem_addr = BOOT_ADDR;
        state_d  = ST_BOOT_W;
      end
      ST_BOOT_W: begin
        busy     = 1'b1;
        pc_load  = 1'b1;
        pc_value = mem_rdata;
        state_d  = ST_IDLE;
      end
      ST_IDLE: begin
        case (op)
          OP_PUSH: begin
            ev_push   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = reg_data;
            sp_dec    = 1'b1;
          end
          OP_CALL: begin
            ev_push   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = DW'(return_addr(32'(pc_in)));
            sp_dec    = 1'b1;
            pc_load   = 1'b1;
            pc_value  = reg_data;
          end
          OP_POP, OP_RET, OP_RTI: begin
            ev_pop_issue = 1'b1;
            mem_re       = 1'b1;
            mem_addr     = sp_up;
            sp_inc       = 1'b1;
            kind_d       = op;
            state_d      = ST_POP_W;
          end
          default: begin
            if (pending && pipe_empty) begin
              ev_int_take = 1'b1;
              busy        = 1'b1;
              mem_we      = 1'b1;
              mem_wdata   = pc_in;
              sp_dec      = 1'b1;
              state_d     = ST_VEC;
            end
          end
        endcase
      end
      ST_POP_W: begin
        busy    = 1'b1;
        state_d = ST_IDLE;
        case (kind_q)
          OP_RET: begin
            pc_load  = 1'b1;
            pc_value = mem_rdata;
          end
          OP_RTI: begin
            pc_load     = 1'b1;
            pc_value    = mem_rdata;
            flags_load  = 1'b1;
            flags_value = shadow;
            ev_rti_done = 1'b1;
          end
          default: begin
            pop_valid = 1'b1;
            pop_data  = mem_rdata;
          end
        endcase
      end
      ST_VEC: begin
        busy     = 1'b1;
        mem_re   = 1'b1;
        mem_addr = VEC_ADDR;
        state_d  = ST_VEC_W;
      end
      ST_VEC_W: begin
        busy     = 1'b1;
        pc_load  = 1'b1;
        pc_value = mem_rdata;
        state_d  = ST_IDLE;
      end
      default: begin
        state_d = ST_BOOT;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_BOOT;
      kind_q  <= OP_NONE;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
    end
  end

endmodule

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter int AW = 20,
  parameter int DW = 32,
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    op_code,
  input  logic [DW-1:0] pc_in,
  input  logic [DW-1:0] reg_data,
  input  logic [FW-1:0] flags_in,
  input  logic          irq,
  input  logic          pipe_empty,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic          pc_load,
  output logic [DW-1:0] pc_value,
  output logic          pop_valid,
  output logic [DW-1:0] pop_data,
  output logic          flags_load,
  output logic [FW-1:0] flags_value,
  output logic          busy,
  output logic [AW-1:0] sp_out
);

  logic [AW-1:0] sp;
  logic [AW-1:0] sp_up;
  logic          sp_dec;
  logic          sp_inc;
  logic          pending;
  logic          in_isr;
  logic [FW-1:0] shadow;
  logic          ev_push;
  logic          ev_pop_issue;
  logic          ev_int_take;
  logic          ev_rti_done;

  assign sp_out = sp;

  stk_sp_unit #(.AW(AW)) u_sp (
    .clk    (clk),
    .rst    (rst),
    .sp_dec (sp_dec),
    .sp_inc (sp_inc),
    .sp     (sp),
    .sp_up  (sp_up)
  );

  stk_irq_unit #(.FW(FW)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .irq      (irq),
    .take     (ev_int_take),
    .done     (ev_rti_done),
    .flags_in (flags_in),
    .pending  (pending),
    .in_isr   (in_isr),
    .shadow   (shadow)
  );

  stk_ctrl #(.AW(AW), .DW(DW), .FW(FW)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .op_code      (op_code),
    .pc_in        (pc_in),
    .reg_data     (reg_data),
    .mem_rdata    (mem_rdata),
    .sp           (sp),
    .sp_up        (sp_up),
    .pending      (pending),
    .pipe_empty   (pipe_empty),
    .shadow       (shadow),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_we       (mem_we),
    .mem_re       (mem_re),
    .pc_load      (pc_load),
    .pc_value     (pc_value),
    .pop_valid    (pop_valid),
    .pop_data     (pop_data),
    .flags_load   (flags_load),
    .flags_value  (flags_value),
    .busy         (busy),
    .sp_dec       (sp_dec),
    .sp_inc       (sp_inc),
    .ev_push      (ev_push),
    .ev_pop_issue (ev_pop_issue),
    .ev_int_take  (ev_int_take),
    .ev_rti_done  (ev_rti_done)
  );

endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] sp,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          mem_re,
  input logic          busy,
  input logic          pipe_empty,
  input logic          pc_load,
  input logic          pop_valid,
  input logic          flags_load,
  input logic          in_isr,
  input logic          ev_push,
  input logic          ev_pop_issue,
  input logic          ev_int_take,
  input logic          ev_rti_done
);

  localparam logic [AW-1:0] SP_INIT = AW'((64'd1 << AW) - 64'd2);

  // R1: reset holds the pointer at its start value and keeps fetch stalled
  p_reset_init_r1: assert property (@(posedge clk)
    rst |=> (sp == SP_INIT) && busy);

  // R2: a single access per cycle
  p_one_access_r2: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  // R3: a push lowers the pointer by one entry
  p_push_step_r3: assert property (@(posedge clk) disable iff (rst)
    ev_push |=> sp == $past(sp) - AW'(2));

  // R4: a pop raises the pointer and delivers a result the next cycle
  p_pop_step_r4: assert property (@(posedge clk) disable iff (rst)
    ev_pop_issue |=> (sp == $past(sp) + AW'(2)) && busy && (pop_valid || pc_load));

  // R8: entry only with a drained pipeline
  p_take_empty_r8: assert property (@(posedge clk) disable iff (rst)
    ev_int_take |-> pipe_empty && busy && mem_we);

  // R9: entry is followed by the vector read at word 1
  p_vector_read_r9: assert property (@(posedge clk) disable iff (rst)
    ev_int_take |=> mem_re && (mem_addr == AW'(1)) && busy);

  // R10: flags come back only with the interrupt return
  p_flags_rti_r10: assert property (@(posedge clk) disable iff (rst)
    flags_load |-> ev_rti_done && pc_load);

  // R11: no second entry while in service
  p_no_nest_r11: assert property (@(posedge clk) disable iff (rst)
    ev_int_take |-> !in_isr);

  // R11: service flag rises right after entry
  p_isr_set_r11: assert property (@(posedge clk) disable iff (rst)
    ev_int_take |=> in_isr);

endmodule

bind stack_seq stack_seq_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sp           (sp),
  .mem_addr     (mem_addr),
  .mem_we       (mem_we),
  .mem_re       (mem_re),
  .busy         (busy),
  .pipe_empty   (pipe_empty),
  .pc_load      (pc_load),
  .pop_valid    (pop_valid),
  .flags_load   (flags_load),
  .in_isr       (in_isr),
  .ev_push      (ev_push),
  .ev_pop_issue (ev_pop_issue),
  .ev_int_take  (ev_int_take),
  .ev_rti_done  (ev_rti_done)
);

// File: tb/stack_seq_tb.sv
module stack_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int Q  = CLK_PERIOD / 4;
  localparam int AW = 20;
  localparam int DW = 32;
  localparam int FW = 3;
  localparam logic [AW-1:0] TOP = AW'((64'd1 << AW) - 64'd2);
  localparam logic [2:0] C_NONE = 3'd0, C_PUSH = 3'd1, C_POP = 3'd2,
                         C_CALL = 3'd3, C_RET = 3'd4, C_RTI = 3'd5;

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    op_code;
  logic [DW-1:0] pc_in, reg_data, mem_rdata;
  logic [FW-1:0] flags_in;
  logic          irq, pipe_empty;
  logic [AW-1:0] mem_addr, sp_out;
  logic [DW-1:0] mem_wdata, pc_value, pop_data;
  logic          mem_we, mem_re, pc_load, pop_valid, flags_load, busy;
  logic [FW-1:0] flags_value;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  logic [15:0]   mem [int];
  logic [AW-1:0] sp_m;
  logic [DW-1:0] stk_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_seq #(.AW(AW), .DW(DW), .FW(FW)) u_dut (
    .clk(clk), .rst(rst), .op_code(op_code), .pc_in(pc_in),
    .reg_data(reg_data), .flags_in(flags_in), .irq(irq),
    .pipe_empty(pipe_empty), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .pc_load(pc_load), .pc_value(pc_value), .pop_valid(pop_valid),
    .pop_data(pop_data), .flags_load(flags_load), .flags_value(flags_value),
    .busy(busy), .sp_out(sp_out)
  );

  function automatic logic [15:0] rdw(input int a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  function automatic int nxt(input logic [AW-1:0] a);
    return int'(AW'(a + AW'(1)));
  endfunction

  // R2 word mapping, restated on the bench side
  function automatic logic [DW-1:0] rd32(input logic [AW-1:0] a);
    return {rdw(nxt(a)), rdw(int'(a))};
  endfunction

  always @(posedge clk) begin
    if (mem_we) begin
      mem[int'(mem_addr)] = mem_wdata[15:0];
      mem[nxt(mem_addr)]  = mem_wdata[31:16];
    end
    if (mem_re) mem_rdata <= rd32(mem_addr);
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_chk(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      op_code = C_NONE;
      #Q;
      check(req, {31'd0, mem_we}, 32'd0);
    end
  endtask

  task automatic t_push(input logic [DW-1:0] d);
    @(negedge clk);
    op_code = C_PUSH; reg_data = d;
    #Q;
    check("R3 push we", {31'd0, mem_we}, 32'd1);
    check("R3 push addr", DW'(mem_addr), DW'(sp_m));
    check("R3 push data", mem_wdata, d);
    @(negedge clk);
    op_code = C_NONE;
    sp_m = sp_m - AW'(2);
    stk_q.push_back(d);
    #Q;
    check("R3 sp after push", DW'(sp_out), DW'(sp_m));
  endtask

  task automatic t_call(input logic [DW-1:0] tgt, input logic [DW-1:0] pc);
    @(negedge clk);
    op_code = C_CALL; reg_data = tgt; pc_in = pc;
    #Q;
    check("R5 call addr", DW'(mem_addr), DW'(sp_m));
    check("R5 call data", mem_wdata, pc + 32'd1);
    check("R5 call pc_load", {31'd0, pc_load}, 32'd1);
    check("R5 call target", pc_value, tgt);
    @(negedge clk);
    op_code = C_NONE;
    sp_m = sp_m - AW'(2);
    stk_q.push_back(pc + 32'd1);
    #Q;
    check("R5 sp after call", DW'(sp_out), DW'(sp_m));
  endtask

  task automatic t_pop(input logic [2:0] kind, input logic [DW-1:0] exp_d,
                       input logic [FW-1:0] exp_f);
    @(negedge clk);
    op_code = kind;
    #Q;
    check("R4 pop re", {31'd0, mem_re}, 32'd1);
    check("R4 pop addr", DW'(mem_addr), DW'(AW'(sp_m + AW'(2))));
    @(negedge clk);
    op_code = C_PUSH; reg_data = 32'hBAD0BAD0;  // offered while busy: R12
    sp_m = sp_m + AW'(2);
    #Q;
    check("R4 busy in result cycle", {31'd0, busy}, 32'd1);
    check("R12 no write while busy", {31'd0, mem_we}, 32'd0);
    if (kind == C_POP) begin
      check("R4 pop_valid", {31'd0, pop_valid}, 32'd1);
      check("R4 pop data", pop_data, exp_d);
    end else begin
      check(kind == C_RET ? "R6 ret pc" : "R10 rti pc", pc_value, exp_d);
      check(kind == C_RET ? "R6 ret load" : "R10 rti load", {31'd0, pc_load}, 32'd1);
      check(kind == C_RET ? "R6 no flags" : "R10 flags_load",
            {31'd0, flags_load}, kind == C_RTI ? 32'd1 : 32'd0);
      if (kind == C_RTI) check("R10 flags value", DW'(flags_value), DW'(exp_f));
    end
    @(negedge clk);
    op_code = C_NONE;
    #Q;
    check("R12 sp unchanged by busy op", DW'(sp_out), DW'(sp_m));
  endtask

  // interrupt entry from the cycle it is taken; flags_in given the entry value
  task automatic t_entry(input logic [DW-1:0] pc, input logic [FW-1:0] f);
    @(negedge clk);
    op_code = C_NONE; pipe_empty = 1'b1; pc_in = pc; flags_in = f;
    #Q;
    check("R9 entry we", {31'd0, mem_we}, 32'd1);
    check("R9 entry busy", {31'd0, busy}, 32'd1);
    check("R9 entry addr", DW'(mem_addr), DW'(sp_m));
    check("R9 entry data", mem_wdata, pc);
    @(negedge clk);
    pipe_empty = 1'b0; flags_in = ~f;
    op_code = C_PUSH; reg_data = 32'h0BADF00D;   // R12: ignored while busy
    sp_m = sp_m - AW'(2);
    stk_q.push_back(pc);
    #Q;
    check("R9 vector read", {31'd0, mem_re}, 32'd1);
    check("R9 vector addr", DW'(mem_addr), 32'd1);
    check("R12 busy op no write", {31'd0, mem_we}, 32'd0);
    @(negedge clk);
    op_code = C_NONE;
    #Q;
    check("R9 vector load", {31'd0, pc_load}, 32'd1);
    check("R9 vector value", pc_value, {16'h9ABC, 16'h1234});
    check("R9 no flags on entry", {31'd0, flags_load}, 32'd0);
    check("R12 sp after busy op", DW'(sp_out), DW'(sp_m));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] junk;
    logic [DW-1:0] d;
    junk = $urandom(32'h5eed);
    rst = 1'b1; op_code = C_NONE; pc_in = '0; reg_data = '0; flags_in = '0;
    irq = 1'b0; pipe_empty = 1'b0;
    mem[0] = 16'h5678; mem[1] = 16'h1234; mem[2] = 16'h9ABC;
    repeat (3) @(negedge clk);
    #Q;
    check("R1 sp in reset", DW'(sp_out), DW'(TOP));
    check("R1 busy in reset", {31'd0, busy}, 32'd1);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #Q;
    check("R1 boot pc_load", {31'd0, pc_load}, 32'd1);
    check("R1 R2 boot pc value", pc_value, 32'h12345678);
    @(negedge clk);
    #Q;
    check("R1 busy released", {31'd0, busy}, 32'd0);
    sp_m = TOP;

    // directed: push at top, word layout, pop
    t_push(32'hDEADBEEF);
    check("R2 low word", {16'd0, rdw(int'(TOP))}, 32'h0000BEEF);
    check("R2 high word", {16'd0, rdw(int'(TOP) + 1)}, 32'h0000DEAD);
    t_pop(C_POP, stk_q.pop_back(), '0);

    // random mix of push, pop, call, return
    for (int i = 0; i < 300; i++) begin
      junk = $urandom % 4;
      if (stk_q.size() == 0 || (stk_q.size() < 40 && junk < 2)) begin
        d = $urandom;
        if (junk[0]) t_call(d, $urandom);
        else t_push(d);
      end else begin
        d = stk_q.pop_back();
        t_pop(junk[0] ? C_RET : C_POP, d, '0);
      end
    end

    // R8: irq edge in the same cycle as a push, pipeline busy
    @(negedge clk);
    op_code = C_PUSH; reg_data = 32'hCAFE0001; irq = 1'b1; pipe_empty = 1'b0;
    #Q;
    check("R8 push served first we", {31'd0, mem_we}, 32'd1);
    check("R8 push served first addr", DW'(mem_addr), DW'(sp_m));
    @(negedge clk);
    op_code = C_NONE;
    sp_m = sp_m - AW'(2);
    stk_q.push_back(32'hCAFE0001);
    idle_chk(3, "R8 held while pipe busy");
    t_entry(32'h00000400, 3'b101);

    // R11: edge during service is dropped
    @(negedge clk); irq = 1'b0;
    @(negedge clk); irq = 1'b1;
    @(negedge clk); pipe_empty = 1'b1;
    idle_chk(4, "R11 no nested entry");
    pipe_empty = 1'b0;
    t_pop(C_RTI, stk_q.pop_back(), 3'b101);
    pipe_empty = 1'b1;
    idle_chk(3, "R11 dropped edge stays dropped");
    t_pop(C_POP, stk_q.pop_back(), '0);

    // second interrupt after service, different flags
    @(negedge clk); irq = 1'b0; pipe_empty = 1'b0;
    @(negedge clk); irq = 1'b1;
    @(negedge clk);
    t_entry(32'h00ABCDEF, 3'b010);
    t_pop(C_RTI, stk_q.pop_back(), 3'b010);
    irq = 1'b0; pipe_empty = 1'b0;

    // drain, then R7 wrap
    while (stk_q.size() > 0) t_pop(C_POP, stk_q.pop_back(), '0);
    check("R7 sp back at top", DW'(sp_out), DW'(TOP));
    t_pop(C_POP, rd32(AW'(0)), '0);
    check("R7 sp wrapped to 0", DW'(sp_out), 32'd0);
    t_push(32'h13572468);
    check("R7 sp wrapped to top", DW'(sp_out), DW'(TOP));

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule